// File: doc/BRIEF.md
# Quadrant Write-Protect and Page Programming Engine

This block sits behind a two-wire serial slave in a 512-byte non-volatile store. The slave hands it decoded transaction headers (operation kind, target quadrant, selected memory half) and each following received byte. The block answers every byte with an ACK or NACK. It gathers page-write data into a 16-byte staging buffer and holds one reversible write-protect bit for each of the four 128-byte quadrants. After the STOP that closes an accepted transaction, it runs a timed programming cycle. During that cycle it reports busy, commits the staged bytes on a byte-wide memory port and applies any protection change.

The store is four 128-byte quadrants, and each quadrant holds eight 16-byte rows. A 9-bit byte address is `{page_sel, word_address[7:0]}`, so address bits [8:7] name the quadrant. A write into a protected quadrant is acknowledged normally but is never programmed. A request to protect an already protected quadrant is refused with NACK on every byte.

States: `ST_IDLE` (waiting for a header), `ST_WADDR` (expecting the word address of a data write), `ST_WDATA` (collecting data bytes), `ST_PROT` (absorbing the don't-care bytes of an accepted protect or unprotect request), `ST_REJECT` (absorbing the bytes of a refused protect request), `ST_PROG` (programming cycle). Transitions:
- `ST_IDLE` goes to `ST_WADDR` on a write header.
- `ST_IDLE` goes to `ST_PROT` on an unprotect header, or on a protect header aimed at an open quadrant.
- `ST_IDLE` goes to `ST_REJECT` on a protect header aimed at a protected quadrant.
- `ST_WADDR` goes to `ST_WDATA` on the word-address byte.
- `ST_WDATA` goes to `ST_PROG` on STOP when at least one byte is staged and the quadrant is open. On any other STOP it goes to `ST_IDLE`.
- `ST_PROT` goes to `ST_PROG` on STOP.
- `ST_REJECT` and `ST_WADDR` go to `ST_IDLE` on STOP.
- Any state except `ST_PROG` goes to `ST_IDLE` on START, and the staged data is discarded.
- `ST_PROG` goes to `ST_IDLE` when the cycle timer expires.

Top module: `quad_prot_write_engine`

## Requirements
- R1: After reset, `busy_o`, `ack_valid_o` and `mem_we_o` are 0, and all four bits of `prot_o` are 0.
- R2: A write header, its word-address byte and each data byte each get one `ack_valid_o` pulse with `ack_o`=1 in the cycle after the input pulse. This holds whether or not the quadrant is protected.
- R3: During a page write, only the low 4 address bits advance after each data byte. A 17th data byte overwrites the column loaded by the first.
- R4: Programming commits only the columns that were loaded in this transaction. Other bytes of the row stay unchanged. The committed address is `{page_sel, word_address[7:4], column}`.
- R5: The programming cycle starts only on STOP. `busy_o` stays high for exactly PROG_CYCLES clocks, whether one byte or sixteen bytes are committed.
- R6: A protect request (`hdr_op_i`=2) aimed at an open quadrant gets ACK on the header and on each byte. After STOP, it runs a programming cycle that sets `prot_o[quad]`.
- R7: A protect request aimed at an already protected quadrant gets NACK on the header and on each byte. No programming cycle follows.
- R8: An unprotect request (`hdr_op_i`=3) gets ACK on every byte and runs a programming cycle, whether or not the quadrant is protected. The cycle clears `prot_o[quad]`.
- R9: A data write into a protected quadrant (address bits [8:7]) starts no programming cycle and changes no memory byte.
- R10: While `busy_o` is high, every header or byte is answered with NACK. These inputs change neither `prot_o` nor memory contents.
- R11: A START that arrives before STOP cancels the pending write, so the following STOP programs nothing.
- R12: The `prot_o` bits change only at the clock edge that ends a programming cycle, and by at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen |
| stop_i | input | 1 | One-cycle pulse: STOP seen |
| hdr_valid_i | input | 1 | One-cycle pulse: a header was decoded |
| hdr_op_i | input | 2 | 0 other, 1 data write, 2 protect, 3 unprotect |
| hdr_quad_i | input | 2 | Target quadrant of a protect or unprotect request |
| page_sel_i | input | 1 | Selected memory half, sampled with the header |
| byte_valid_i | input | 1 | One-cycle pulse: a byte after the header was received |
| byte_i | input | 8 | Received byte |
| ack_valid_o | output | 1 | Response for the last header or byte is valid |
| ack_o | output | 1 | 1 = ACK, 0 = NACK |
| busy_o | output | 1 | Programming cycle in progress |
| prot_o | output | 4 | Write-protect bit per quadrant |
| mem_we_o | output | 1 | Memory byte write strobe |
| mem_addr_o | output | 9 | Memory byte address |
| mem_data_o | output | 8 | Memory byte data |

## Verification
The assertions assume that the slave pulses `start_i`, `stop_i`, `hdr_valid_i` and `byte_valid_i` one at a time. They also assume that a header arrives only as the first event after a START. The bench keeps to this by driving each event as a separate one-cycle pulse, with an idle cycle between events. It always issues a START before a header and never drives bytes without a preceding header.

// File: rtl/qp_pkg.sv
package qp_pkg;
    typedef enum logic [1:0] {
        OP_OTHER = 2'd0,
        OP_WRITE = 2'd1,
        OP_SETP  = 2'd2,
        OP_CLRP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WDATA,
        ST_PROT,
        ST_REJECT,
        ST_PROG
    } st_e;
endpackage

// File: rtl/qp_prot_regs.sv
module qp_prot_regs #(
    parameter int NUM_QUADS = 4,
    localparam int QW = $clog2(NUM_QUADS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_i,
    input  logic                 set_i,
    input  logic [QW-1:0]        idx_i,
    output logic [NUM_QUADS-1:0] bits_o
);
    for (genvar q = 0; q < NUM_QUADS; q++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bits_o[q] <= 1'b0;
            else if (upd_i && idx_i == QW'(q))
                bits_o[q] <= set_i;
        end
    end

    // R12: at most one quadrant bit moves per edge
    a_r12_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bits_o ^ $past(bits_o)) <= 1);
endmodule

// File: rtl/qp_page_buf.sv
module qp_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int COL_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [COL_W-1:0] wcol_i,
    input  logic [7:0]       wdata_i,
    input  logic [COL_W-1:0] rcol_i,
    output logic [7:0]       rdata_o,
    output logic             rvalid_o,
    output logic             any_o
);
    logic [7:0]            data_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;

    for (genvar c = 0; c < PAGE_BYTES; c++) begin : g_col
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[c] <= 8'h00;
                mask_q[c] <= 1'b0;
            end else if (clr_i) begin
                mask_q[c] <= 1'b0;
            end else if (wr_i && wcol_i == COL_W'(c)) begin
                data_q[c] <= wdata_i;
                mask_q[c] <= 1'b1;
            end
        end
    end

    assign rdata_o  = data_q[rcol_i];
    assign rvalid_o = mask_q[rcol_i];
    assign any_o    = |mask_q;

    // R11: a clear leaves no column marked as loaded
    a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !any_o);
endmodule

// File: rtl/qp_prog_timer.sv
module qp_prog_timer #(
    parameter int CYCLES = 50000,
    localparam int CW = $clog2(CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (!run_i)
            cnt_o <= '0;
        else
            cnt_o <= cnt_o + 1'b1;
    end

    assign done_o = run_i && (cnt_o == CW'(CYCLES - 1));

    // R5: the count never runs past the programming window
    a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> cnt_o < CW'(CYCLES));
endmodule

// File: rtl/quad_prot_write_engine.sv
module quad_prot_write_engine
    import qp_pkg::*;
#(
    parameter int PROG_CYCLES = 50000,
    parameter int PAGE_BYTES  = 16,
    parameter int NUM_QUADS   = 4,
    parameter int ADDR_W      = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              hdr_valid_i,
    input  logic [1:0]        hdr_op_i,
    input  logic [1:0]        hdr_quad_i,
    input  logic              page_sel_i,
    input  logic              byte_valid_i,
    input  logic [7:0]        byte_i,
    output logic              ack_valid_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic [3:0]        prot_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_data_o
);
    localparam int COL_W = $clog2(PAGE_BYTES);
    localparam int QW    = $clog2(NUM_QUADS);
    localparam int CW    = $clog2(PROG_CYCLES + 1);
    localparam int WA_W  = ADDR_W - 1;

    st_e             st, st_n;
    op_e             op_q, hop;
    logic [QW-1:0]   quad_q;
    logic            ps_q;
    logic [WA_W-1:0] waddr_q;
    logic [COL_W-1:0] col_q;

    logic r_valid, r_ack, hdr_take, waddr_ld, buf_wr, buf_clr, prot_upd;
    logic [CW-1:0]   tmr_cnt;
    logic            tmr_done, buf_any, buf_rvalid;
    logic [7:0]      buf_rdata;
    logic [ADDR_W-1:0] full_addr;
    logic [QW-1:0]   wquad;

    assign hop       = op_e'(hdr_op_i);
    assign full_addr = {ps_q, waddr_q};
    assign wquad     = full_addr[ADDR_W-1 -: QW];

    qp_prot_regs #(.NUM_QUADS(NUM_QUADS)) u_prot (
        .clk(clk), .rst_n(rst_n), .upd_i(prot_upd), .set_i(op_q == OP_SETP),
        .idx_i(quad_q), .bits_o(prot_o)
    );

    qp_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr),
        .wcol_i(col_q), .wdata_i(byte_i), .rcol_i(tmr_cnt[COL_W-1:0]),
        .rdata_o(buf_rdata), .rvalid_o(buf_rvalid), .any_o(buf_any)
    );

    qp_prog_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run_i(st == ST_PROG),
        .cnt_o(tmr_cnt), .done_o(tmr_done)
    );

    // next state and response
    always_comb begin
        st_n = st; r_valid = 1'b0; r_ack = 1'b0; hdr_take = 1'b0;
        waddr_ld = 1'b0; buf_wr = 1'b0; buf_clr = 1'b0; prot_upd = 1'b0;
        if (st == ST_PROG) begin
            r_valid = hdr_valid_i | byte_valid_i;
            if (tmr_done) begin
                st_n     = ST_IDLE;
                buf_clr  = 1'b1;
                prot_upd = (op_q == OP_SETP) || (op_q == OP_CLRP);
            end
        end else if (start_i) begin
            st_n    = ST_IDLE;
            buf_clr = 1'b1;
        end else if (stop_i) begin
            st_n    = ST_IDLE;
            buf_clr = 1'b1;
            if (st == ST_PROT ||
                (st == ST_WDATA && buf_any && !prot_o[wquad])) begin
                st_n    = ST_PROG;
                buf_clr = 1'b0;
            end
        end else begin
            unique case (st)
                ST_IDLE: if (hdr_valid_i && hop != OP_OTHER) begin
                    hdr_take = 1'b1;
                    r_valid  = 1'b1;
                    r_ack    = 1'b1;
                    if (hop == OP_WRITE)
                        st_n = ST_WADDR;
                    else if (hop == OP_SETP && prot_o[hdr_quad_i[QW-1:0]]) begin
                        st_n  = ST_REJECT;
                        r_ack = 1'b0;
                    end else
                        st_n = ST_PROT;
                end
                ST_WADDR: if (byte_valid_i) begin
                    r_valid  = 1'b1;
                    r_ack    = 1'b1;
                    waddr_ld = 1'b1;
                    st_n     = ST_WDATA;
                end
                ST_WDATA: if (byte_valid_i) begin
                    r_valid = 1'b1;
                    r_ack   = 1'b1;
                    buf_wr  = 1'b1;
                end
                ST_PROT: begin
                    r_valid = byte_valid_i;
                    r_ack   = 1'b1;
                end
                ST_REJECT: r_valid = byte_valid_i;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // state and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE; op_q <= OP_OTHER; quad_q <= '0; ps_q <= 1'b0;
            waddr_q <= '0; col_q <= '0; ack_valid_o <= 1'b0; ack_o <= 1'b0;
        end else begin
            st          <= st_n;
            ack_valid_o <= r_valid;
            ack_o       <= r_ack;
            if (hdr_take) begin
                op_q   <= hop;
                quad_q <= hdr_quad_i[QW-1:0];
                ps_q   <= page_sel_i;
            end
            if (waddr_ld) begin
                waddr_q <= byte_i[WA_W-1:0];
                col_q   <= byte_i[COL_W-1:0];
            end else if (buf_wr)
                col_q <= col_q + 1'b1;
        end
    end

    assign busy_o     = (st == ST_PROG);
    assign mem_we_o   = busy_o && op_q == OP_WRITE &&
                        tmr_cnt < CW'(PAGE_BYTES) && buf_rvalid;
    assign mem_addr_o = {full_addr[ADDR_W-1:COL_W], tmr_cnt[COL_W-1:0]};
    assign mem_data_o = buf_rdata;

    // R10: anything received while busy is refused
    a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && (hdr_valid_i || byte_valid_i) |=> ack_valid_o && !ack_o);
    // R7: protect request on a protected quadrant is refused
    a_r7_reject_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && st == ST_IDLE && !start_i && !stop_i && hdr_valid_i &&
        hop == OP_SETP && prot_o[hdr_quad_i[QW-1:0]] |=> ack_valid_o && !ack_o);
    // R5: programming begins only on STOP
    a_r5_start_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));
    // R12: protection moves only as a cycle ends
    a_r12_prot_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_o) |-> $past(busy_o) && !busy_o);
    // R4: memory is written only inside the cycle
    a_r4_we_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);
endmodule

// File: tb/quad_prot_write_engine_bench.sv
module quad_prot_write_engine_bench;
    localparam int PROG = 40;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, stop_i = 0, hdr_valid_i = 0, page_sel_i = 0, byte_valid_i = 0;
    logic [1:0] hdr_op_i = 0, hdr_quad_i = 0;
    logic [7:0] byte_i = 0;
    logic ack_valid_o, ack_o, busy_o, mem_we_o;
    logic [3:0] prot_o;
    logic [8:0] mem_addr_o;
    logic [7:0] mem_data_o;

    int n_run = 0, n_fail = 0;
    logic [7:0] mem [512];

    always #5 clk = ~clk;

    quad_prot_write_engine #(.PROG_CYCLES(PROG)) u_quad_prot_write_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .hdr_valid_i(hdr_valid_i), .hdr_op_i(hdr_op_i), .hdr_quad_i(hdr_quad_i),
        .page_sel_i(page_sel_i), .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o), .busy_o(busy_o), .prot_o(prot_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
    );

    always @(posedge clk) if (mem_we_o) mem[mem_addr_o] <= mem_data_o;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask
    task automatic do_stop();
        @(negedge clk) stop_i = 1;
        @(negedge clk) stop_i = 0;
    endtask
    // header: returns {valid, ack} seen the cycle after
    task automatic do_hdr(input int op, input int q, input bit ps, output logic [1:0] r);
        @(negedge clk) begin hdr_valid_i = 1; hdr_op_i = 2'(op); hdr_quad_i = 2'(q); page_sel_i = ps; end
        @(negedge clk) begin hdr_valid_i = 0; r = {ack_valid_o, ack_o}; end
    endtask
    task automatic do_byte(input logic [7:0] b, output logic [1:0] r);
        @(negedge clk) begin byte_valid_i = 1; byte_i = b; end
        @(negedge clk) begin byte_valid_i = 0; r = {ack_valid_o, ack_o}; end
    endtask
    task automatic wait_idle(output int cycles);
        cycles = 0;
        while (busy_o && cycles < 1000) begin @(negedge clk); cycles++; end
    endtask
    task automatic fill_mem();
        for (int i = 0; i < 512; i++) mem[i] = 8'hEE;
    endtask

    // generic data write; returns busy length (0 if none)
    task automatic wr_txn(input bit ps, input logic [7:0] wa, input int n,
                          input logic [7:0] seed, input string req, output int len);
        logic [1:0] r;
        do_start();
        do_hdr(1, 0, ps, r);
        chk(r == 2'b11, {req, " R2 hdr ack"}, r, 3);
        do_byte(wa, r);
        chk(r == 2'b11, {req, " R2 addr ack"}, r, 3);
        for (int i = 0; i < n; i++) begin
            do_byte(seed + 8'(i), r);
            if (r != 2'b11) chk(0, {req, " R2 data ack"}, r, 3);
        end
        do_stop();
        wait_idle(len);
    endtask

    task automatic t_reset();
        chk(!busy_o && !ack_valid_o && !mem_we_o && prot_o == 0, "R1 reset", {busy_o, ack_valid_o, mem_we_o, prot_o}, 0);
    endtask

    task automatic t_byte_write();
        int len;
        fill_mem();
        wr_txn(0, 8'h23, 1, 8'h5A, "R2", len);
        chk(mem[9'h023] == 8'h5A, "R4 byte committed", mem[9'h023], 8'h5A);
        chk(mem[9'h022] == 8'hEE && mem[9'h024] == 8'hEE, "R4 neighbours", {mem[9'h022], mem[9'h024]}, 16'hEEEE);
        chk(len == PROG, "R5 single byte busy length", len, PROG);
    endtask

    task automatic t_page_wrap();
        int len;
        logic [7:0] e;
        fill_mem();
        wr_txn(0, 8'h1C, 18, 8'h10, "R3", len);
        // bytes i=0..17 land at column (12+i)%16; i=16,17 overwrite cols 12,13
        for (int c = 0; c < 16; c++) begin
            e = (c == 12) ? 8'h20 : (c == 13) ? 8'h21 : 8'h10 + 8'((c - 12 + 16) % 16);
            chk(mem[9'h010 + c] == e, "R3 wrap column", mem[9'h010 + c], e);
        end
        chk(mem[9'h020] == 8'hEE, "R3 next row untouched", mem[9'h020], 8'hEE);
        chk(len == PROG, "R5 full page busy length", len, PROG);
    endtask

    task automatic t_partial();
        int len;
        fill_mem();
        wr_txn(1, 8'h45, 3, 8'hA0, "R4", len);
        chk(mem[9'h145] == 8'hA0 && mem[9'h146] == 8'hA1 && mem[9'h147] == 8'hA2, "R4 upper half bytes",
            mem[9'h146], 8'hA1);
        chk(mem[9'h144] == 8'hEE && mem[9'h148] == 8'hEE && mem[9'h045] == 8'hEE, "R4 unloaded columns",
            mem[9'h144], 8'hEE);
    endtask

    task automatic prot_txn(input int op, input int q, input logic [1:0] exp_r,
                            input string req, output int len);
        logic [1:0] r;
        do_start();
        do_hdr(op, q, 0, r);
        chk(r == exp_r, {req, " hdr response"}, r, exp_r);
        do_byte(8'h00, r);
        chk(r == exp_r, {req, " byte1 response"}, r, exp_r);
        do_byte(8'hFF, r);
        chk(r == exp_r, {req, " byte2 response"}, r, exp_r);
        do_stop();
        wait_idle(len);
    endtask

    task automatic t_protect();
        int len;
        prot_txn(2, 1, 2'b11, "R6", len);
        chk(len == PROG, "R6 cycle ran", len, PROG);
        chk(prot_o == 4'b0010, "R6 bit set", prot_o, 2);
        prot_txn(2, 1, 2'b10, "R7", len);
        chk(len == 0, "R7 no cycle", len, 0);
        chk(prot_o == 4'b0010, "R7 bits kept", prot_o, 2);
    endtask

    task automatic t_write_protected();
        int len;
        fill_mem();
        wr_txn(0, 8'h90, 2, 8'h33, "R9", len);
        chk(len == 0, "R9 no cycle", len, 0);
        chk(mem[9'h090] == 8'hEE && mem[9'h091] == 8'hEE, "R9 memory unchanged", mem[9'h090], 8'hEE);
    endtask

    task automatic t_unprotect();
        int len;
        prot_txn(3, 1, 2'b11, "R8", len);
        chk(len == PROG && prot_o == 4'b0000, "R8 cleared", prot_o, 0);
        prot_txn(3, 2, 2'b11, "R8 open", len);
        chk(len == PROG && prot_o == 4'b0000, "R8 open quadrant cycle", len, PROG);
    endtask

    task automatic t_busy_ignore();
        logic [1:0] r;
        int len;
        fill_mem();
        do_start();
        do_hdr(1, 0, 0, r); do_byte(8'h60, r); do_byte(8'h77, r);
        do_stop();
        do_hdr(2, 3, 0, r);
        chk(r == 2'b10, "R10 header nack while busy", r, 2);
        do_byte(8'h99, r);
        chk(r == 2'b10, "R10 byte nack while busy", r, 2);
        do_stop();
        wait_idle(len);
        chk(prot_o == 4'b0000, "R10 prot unchanged", prot_o, 0);
        chk(mem[9'h060] == 8'h77 && mem[9'h061] == 8'hEE, "R10 memory only original", mem[9'h061], 8'hEE);
    endtask

    task automatic t_restart_cancel();
        logic [1:0] r;
        int len;
        fill_mem();
        do_start();
        do_hdr(1, 0, 0, r); do_byte(8'h70, r); do_byte(8'h12, r);
        do_start();
        do_stop();
        @(negedge clk);
        len = busy_o ? 1 : 0;
        chk(len == 0, "R11 no cycle after restart", len, 0);
        wait_idle(len);
        chk(mem[9'h070] == 8'hEE, "R11 memory unchanged", mem[9'h070], 8'hEE);
    endtask

    task automatic t_prot_timing();
        int cyc;
        logic [1:0] r;
        do_start();
        do_hdr(2, 0, 0, r); do_byte(0, r); do_byte(0, r);
        do_stop();
        cyc = 0;
        while (busy_o && cyc < 1000) begin
            if (prot_o != 0) chk(0, "R12 changed during cycle", prot_o, 0);
            @(negedge clk); cyc++;
        end
        chk(prot_o == 4'b0001, "R12 set at cycle end", prot_o, 1);
    endtask

    initial begin
        fork
            begin
                #20000000;
                n_fail++;
                $display("FAIL watchdog expired");
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_page_wrap();
        t_partial();
        t_protect();
        t_write_protected();
        t_unprotect();
        t_busy_ignore();
        t_restart_cancel();
        t_prot_timing();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule